// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block holds the interrupt status and interrupt enable registers of a DMA engine. A register port writes and reads them. Single-cycle event pulses from the transmit and receive engines set sticky status bits. Software acknowledges an event by writing a 1 to its bit. The block groups the enabled sources into a normal summary and an abnormal summary. Each summary has its own group enable. A single level interrupt line is asserted while either summary is set.

The upper part of the status word is read-only. It shows the current transmit and receive process states, which come in as inputs. Writes never reach that part. Reads return the selected register combinationally on the same cycle as the address. The interrupt line comes from a flop, so it follows the summaries one cycle later.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, every sticky source bit and every enable bit is 0, and `irq` is low.
- R2: A 1 on `ev_in[i]` sets status bit i one clock later, for i in {0..10, 13, 14}. The bit then stays set until software clears it.
- R3: A write to the status register (`reg_addr` = 0) clears each source bit whose write-data bit is 1. Source bits whose write-data bit is 0 are left unchanged.
- R4: If an event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 22:20 read back `tx_state`, and bits 19:17 read back `rx_state`. Bits 31:23, 12 and 11 read 0. A write to the status register changes none of these bits.
- R6: The enable register (`reg_addr` = 1) stores write-data bits 0..10, 13, 14, 15 and 16, and reads them back. All other enable bits read 0.
- R7: Status bit 16 (normal summary) is 1 exactly when enable bit 16 is 1 and at least one of source bits 0, 2, 6 or 14 is set with its enable bit set.
- R8: Status bit 15 (abnormal summary) is 1 exactly when enable bit 15 is 1 and at least one of source bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 is set with its enable bit set.
- R9: `irq` equals the OR of the two summary bits as they stood one cycle earlier. It therefore drops on the clock after the last contributing bit is cleared.
- R10: Pulses on `ev_in[11]` and `ev_in[12]` are ignored: status bits 11 and 12 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | 15 | Event pulses, one per source bit position |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_addr | input | 2 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| tx_state | input | 3 | Current transmit process state |
| rx_state | input | 3 | Current receive process state |
| irq | output | 1 | Level interrupt |

## Verification
The random part sends sparse event pulses mixed with random writes to both registers. It sweeps enable masks and group enables, so the bench can tell a source gated by its own enable from one gated by its group enable, and the normal group from the abnormal group. Directed cases put an event and a clear on the same bit in one cycle, which separates set priority from clear priority. They also write all ones to the status word, which exposes any write that leaks into the read-only state fields or the unused bits. A final case clears the last contributing source and watches `irq`, which confirms the one-cycle drop.

// File: rtl/dma_irq_pkg.sv
// Package: shared bit masks and register selects of the DMA interrupt status block.
// Assumes a 15-bit source field with positions 11 and 12 unused.
package dma_irq_pkg;
    localparam int SRC_W = 15;
    localparam logic [SRC_W-1:0] SRC_MASK  = 15'h67FF;
    localparam logic [SRC_W-1:0] NORM_MASK = 15'h4045;
    localparam logic [SRC_W-1:0] ABN_MASK  = 15'h27BA;
    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_ENABLE = 2'd1;
endpackage

// File: rtl/dma_irq_sticky.sv
// Sticky status bank: one flop per implemented source bit. Set has priority over
// write-1-to-clear. Assumes clear requests are already qualified by the write decode.
module dma_irq_sticky #(
    parameter int              SRC_W = 15,
    parameter logic [SRC_W-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_i,
    input  logic [SRC_W-1:0] clr_i,
    output logic [SRC_W-1:0] bits_o
);
    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            logic q;
            // Hold, set on event, clear on acknowledge; set wins.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= 1'b0;
                else if (set_i[i]) q <= 1'b1;
                else if (clr_i[i]) q <= 1'b0;
            end
            assign bits_o[i] = q;
        end else begin : g_none
            assign bits_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/dma_irq_enable.sv
// Enable register: per-source enables plus two group enables.
// Assumes the write strobe is already decoded for this register.
module dma_irq_enable #(
    parameter int              SRC_W = 15,
    parameter logic [SRC_W-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SRC_W-1:0] src_d,
    input  logic             norm_d,
    input  logic             abn_d,
    output logic [SRC_W-1:0] src_q,
    output logic             norm_q,
    output logic             abn_q
);
    // Load all enable fields on a write; unimplemented source bits stay 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            norm_q <= 1'b0;
            abn_q  <= 1'b0;
        end else if (wr_i) begin
            src_q  <= src_d & MASK;
            norm_q <= norm_d;
            abn_q  <= abn_d;
        end
    end
endmodule

// File: rtl/dma_irq_summary.sv
// Group summary: OR of the enabled sources of one group, gated by the group enable.
// Purely combinational; assumes the inputs come from flops.
module dma_irq_summary #(
    parameter int              SRC_W = 15,
    parameter logic [SRC_W-1:0] GROUP = '0
) (
    input  logic [SRC_W-1:0] bits_i,
    input  logic [SRC_W-1:0] en_i,
    input  logic             grp_en_i,
    output logic             sum_o
);
    // Reduce the masked, enabled sources.
    always_comb sum_o = grp_en_i & (|(bits_i & en_i & GROUP));
endmodule

// File: rtl/dma_irq_status.sv
// Top: DMA interrupt status and enable registers behind a one-cycle register port.
// Status source bits are sticky and write-1-to-clear. The summaries are derived,
// the state fields are read-only, and irq is registered from the summaries.
// Assumes single-cycle event pulses and a read that is valid while reg_addr is held.
module dma_irq_status #(
    parameter int DATA_W  = 32,
    parameter int ST_W    = 3,
    parameter int TX_LSB  = 20,
    parameter int RX_LSB  = 17,
    parameter int NSUM_BIT = 16,
    parameter int ASUM_BIT = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [dma_irq_pkg::SRC_W-1:0] ev_in,
    input  logic                         reg_wr,
    input  logic [1:0]                   reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    input  logic [ST_W-1:0]              tx_state,
    input  logic [ST_W-1:0]              rx_state,
    output logic                         irq
);
    import dma_irq_pkg::*;

    logic [SRC_W-1:0] sticky_q, clr_req, en_src_q;
    logic             nie_q, aie_q, wr_status, wr_enable;
    logic             nis, ais;
    logic [DATA_W-1:0] status_word, enable_word;

    // Decode the register port.
    always_comb begin
        wr_status = reg_wr && (reg_addr == SEL_STATUS);
        wr_enable = reg_wr && (reg_addr == SEL_ENABLE);
        clr_req   = wr_status ? reg_wdata[SRC_W-1:0] : '0;
    end

    dma_irq_sticky #(.SRC_W(SRC_W), .MASK(SRC_MASK)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set_i(ev_in), .clr_i(clr_req), .bits_o(sticky_q)
    );

    dma_irq_enable #(.SRC_W(SRC_W), .MASK(SRC_MASK)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_enable),
        .src_d(reg_wdata[SRC_W-1:0]), .norm_d(reg_wdata[NSUM_BIT]), .abn_d(reg_wdata[ASUM_BIT]),
        .src_q(en_src_q), .norm_q(nie_q), .abn_q(aie_q)
    );

    dma_irq_summary #(.SRC_W(SRC_W), .GROUP(NORM_MASK)) u_norm (
        .bits_i(sticky_q), .en_i(en_src_q), .grp_en_i(nie_q), .sum_o(nis)
    );

    dma_irq_summary #(.SRC_W(SRC_W), .GROUP(ABN_MASK)) u_abn (
        .bits_i(sticky_q), .en_i(en_src_q), .grp_en_i(aie_q), .sum_o(ais)
    );

    // Assemble the read words.
    always_comb begin
        status_word = '0;
        status_word[SRC_W-1:0]            = sticky_q;
        status_word[NSUM_BIT]             = nis;
        status_word[ASUM_BIT]             = ais;
        status_word[TX_LSB +: ST_W]       = tx_state;
        status_word[RX_LSB +: ST_W]       = rx_state;
        enable_word = '0;
        enable_word[SRC_W-1:0]            = en_src_q;
        enable_word[NSUM_BIT]             = nie_q;
        enable_word[ASUM_BIT]             = aie_q;
    end

    // Read mux.
    always_comb begin
        case (reg_addr)
            SEL_STATUS: reg_rdata = status_word;
            SEL_ENABLE: reg_rdata = enable_word;
            default:    reg_rdata = '0;
        endcase
    end

    // Register the interrupt line from the summaries.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= nis | ais;
    end
endmodule

// File: rtl/dma_irq_status_chk.sv
// Checker for dma_irq_status, bound to every instance. Relates the ports to the
// sticky and enable state over time.
module dma_irq_status_chk #(
    parameter int SRC_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_W-1:0] ev_in,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [2:0]       tx_state,
    input logic [2:0]       rx_state,
    input logic             irq,
    input logic [SRC_W-1:0] sticky,
    input logic [SRC_W-1:0] en_src,
    input logic             nie,
    input logic             aie
);
    import dma_irq_pkg::*;
    logic past_ok;
    logic [SRC_W-1:0] ev_m;
    logic exp_any;

    // Becomes 1 one clock after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        ev_m    = ev_in & SRC_MASK;
        exp_any = (nie && |(sticky & en_src & NORM_MASK)) ||
                  (aie && |(sticky & en_src & ABN_MASK));
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> ((sticky & $past(ev_m)) == $past(ev_m)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !(reg_wr && reg_addr == SEL_STATUS)) |=> ((sticky & $past(sticky)) == $past(sticky)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && reg_wr && reg_addr == SEL_STATUS)
        |=> ((sticky & $past(reg_wdata[SRC_W-1:0] & ~ev_in)) == '0));

    p_ro_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == SEL_STATUS) |-> (reg_rdata[22:20] == tx_state && reg_rdata[19:17] == rx_state
                                      && reg_rdata[31:23] == '0));

    p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (sticky[12:11] == 2'b00));

    p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> (irq == $past(exp_any)));
endmodule

bind dma_irq_status dma_irq_status_chk #(.SRC_W(dma_irq_pkg::SRC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_state(tx_state), .rx_state(rx_state),
    .irq(irq), .sticky(sticky_q), .en_src(en_src_q), .nie(nie_q), .aie(aie_q)
);

// File: tb/dma_irq_status_tb.sv
// Bench: seeded random traffic plus directed corner cases against a bench model.
module dma_irq_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ev_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  tx_state = '0, rx_state = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [14:0] m_st = '0, m_en = '0;
    logic        m_nie = 1'b0, m_aie = 1'b0;
    bit          done = 1'b0;

    localparam logic [14:0] IMPL = 15'h67FF;
    localparam logic [14:0] NRM  = 15'h4045;
    localparam logic [14:0] ABN  = 15'h27BA;

    always #2 clk = ~clk;

    dma_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_state(tx_state), .rx_state(rx_state),
        .irq(irq)
    );

    function automatic logic f_nis();
        return m_nie && |(m_st & m_en & NRM);
    endfunction
    function automatic logic f_ais();
        return m_aie && |(m_st & m_en & ABN);
    endfunction
    function automatic logic [31:0] f_read(input logic [1:0] a);
        logic [31:0] w = '0;
        if (a == 2'd0) begin
            w[14:0] = m_st; w[16] = f_nis(); w[15] = f_ais();
            w[22:20] = tx_state; w[19:17] = rx_state;
        end else if (a == 2'd1) begin
            w[14:0] = m_en; w[16] = m_nie; w[15] = m_aie;
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock of stimulus, starting and ending at a falling edge; checks read data and irq.
    task automatic step(input string tag, input logic [14:0] ev, input logic wr,
                        input logic [1:0] a, input logic [31:0] wd);
        logic exp_irq;
        ev_in = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        exp_irq = f_nis() | f_ais();
        @(posedge clk);
        if (wr && a == 2'd0) m_st = m_st & ~wd[14:0];
        if (wr && a == 2'd1) begin m_en = wd[14:0] & IMPL; m_nie = wd[16]; m_aie = wd[15]; end
        m_st = (m_st | ev) & IMPL;
        @(negedge clk);
        check(tag, reg_rdata, f_read(a));
        check({tag, " R9"}, {31'd0, irq}, {31'd0, exp_irq});
        ev_in = '0; reg_wr = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [1:0] a);
        reg_addr = a; #1;
        check(tag, reg_rdata, f_read(a));
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        peek("R1 status", 2'd0);
        peek("R1 enable", 2'd1);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R6: enable write, unimplemented bits dropped
        step("R6", '0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        // R2/R7: normal source sets bit 0 and summary 16
        step("R2 R7", 15'h0001, 1'b0, 2'd0, '0);
        step("R7 hold", '0, 1'b0, 2'd0, '0);
        check("R7 irq", {31'd0, irq}, 32'd1);
        // R4: set and clear same bit same cycle
        step("R4", 15'h0001, 1'b1, 2'd0, 32'h0000_0001);
        check("R4 bit", {31'd0, reg_rdata[0]}, 32'd1);
        // R3/R9: clear the last source; irq drops one cycle later
        step("R3", '0, 1'b1, 2'd0, 32'h0000_0001);
        step("R9 drop", '0, 1'b0, 2'd0, '0);
        check("R9 low", {31'd0, irq}, 32'd0);
        // R8: abnormal source with abnormal group enabled only
        step("R8 en", '0, 1'b1, 2'd1, 32'h0000_A7FF);
        step("R8", 15'h2000, 1'b0, 2'd0, '0);
        check("R8 bit15", {31'd0, reg_rdata[15]}, 32'd1);
        step("R8 nis off", 15'h0004, 1'b0, 2'd0, '0);
        check("R7 gated", {31'd0, reg_rdata[16]}, 32'd0);
        // R10: unused positions ignored
        step("R10", 15'h1800, 1'b0, 2'd0, '0);
        check("R10 bits", {30'd0, reg_rdata[12:11]}, 32'd0);
        // R5: all-ones write to status leaves RO fields alone
        tx_state = 3'b110; rx_state = 3'b101;
        step("R5", '0, 1'b1, 2'd0, 32'hFFFF_FFFF);
        check("R5 tx", {29'd0, reg_rdata[22:20]}, 32'd6);
        check("R5 rx", {29'd0, reg_rdata[19:17]}, 32'd5);

        // Random traffic covering R2 R3 R6 R7 R8 R9
        for (int k = 0; k < 3000; k++) begin
            logic [14:0] ev = 15'($urandom & $urandom & $urandom);
            logic        wr = ($urandom % 3) == 0;
            logic [1:0]  a  = 2'($urandom % 3);
            logic [31:0] wd = $urandom;
            tx_state = 3'($urandom); rx_state = 3'($urandom);
            step("R2 R3 R7 R8 rand", ev, wr, a, wd);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule